// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a CPU-facing configuration register file that sits behind two I/O addresses. A write to the index address latches an 8-bit register number. A read or write at the data address then reaches the register that number selects. The registers hold the machine setup: reset status and reset requests, machine type and video timing, a RAM page used while configuring, three peripheral setting bytes and a CPU turbo bit. The settings drive output pins that the video, audio and memory logic elsewhere in the chip consume.

Which registers accept writes depends on the boot phase. While the boot ROM overlay is on, or while the machine type is still 00 (config mode), the machine-type register is open. Any accepted write to it turns the overlay off, so the lowest 16 KB then maps to RAM. The configuration RAM page is open only in config mode with the overlay off. Three reset kinds arrive as inputs. Power-on and hard reset restore every default. Soft reset keeps the setup but records itself in the status register. The block raises a one-cycle request when software asks for a hard or soft reset.

Top module: `cfgport_top`

## Requirements
- R1: A write at address IDX_PORT stores io_wdata as the register index at the next clock edge. A read at IDX_PORT returns 0x00. Every reset (power-on, hard or soft) clears the index to 0x00.
- R2: io_rdata is combinational. It shows the selected register's value while io_rd is high and io_addr equals DAT_PORT, and 0x00 at all other times. Index 0x00 reads MACH_ID and index 0x01 reads CORE_VER. Writes to these two indices have no effect.
- R3: Index 0x02 reads {5'b0, por_flag, hard_flag, soft_flag}. Exactly one flag is set, the one for the most recent reset: 0x04 after power-on, 0x02 after a hard reset, 0x01 after a soft reset. Writes do not change these flags.
- R4: A write of a value with bit 1 set to index 0x02 drives hard_req_o high for exactly the one cycle after the write edge. If bit 1 is clear and bit 0 is set, the write drives soft_req_o instead. hard_req_o and soft_req_o are never high together.
- R5: Index 0x03 accepts a write only while rom_overlay_o is 1 or mach_type_o is 00. An accepted write loads timing_o from bits 4:3 and mach_type_o from bits 1:0, ignores the reserved bits and clears rom_overlay_o. Any other write to index 0x03 leaves the machine type, the timing and the overlay unchanged.
- R6: Index 0x04 accepts a write only while rom_overlay_o is 0 and mach_type_o is 00. An accepted write loads boot_page_o from bits 4:0. Any other write to index 0x04 leaves boot_page_o unchanged.
- R7: Indices 0x03 and 0x04 read 0x00. Any index outside 0x00 to 0x08 reads 0x00, and a write to it changes no output.
- R8: Indices 0x05 and 0x06 are 8-bit read/write registers driving per1_o and per2_o. Index 0x07 stores only bit 0, drives turbo_o and reads {7'b0, turbo}. Index 0x08 stores bits 5:0 into per3_o, and its bits 7:6 read as 0.
- R9: After a power-on or hard reset: mach_type_o=00, timing_o=00, boot_page_o=0, rom_overlay_o=1, per1_o=0x01, per2_o=0x00, turbo_o=0 and per3_o=0x10.
- R10: A soft reset leaves the machine type, timing, overlay, boot page, peripheral bytes and turbo unchanged.
- R11: Resets take priority in the order power-on, hard, soft, and any reset wins over a bus write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hard_rst | input | 1 | Synchronous hard reset |
| soft_rst | input | 1 | Synchronous soft reset |
| io_addr | input | AW | CPU I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (0x00 when not selected) |
| rom_overlay_o | output | 1 | Boot ROM mapped at the lowest 16 KB |
| hard_req_o | output | 1 | One-cycle hard reset request |
| soft_req_o | output | 1 | One-cycle soft reset request |
| mach_type_o | output | 2 | Machine type, 00 means config mode |
| timing_o | output | 2 | Video timing select |
| boot_page_o | output | PAGE_W | RAM page used in config mode |
| per1_o | output | 8 | Peripheral settings byte 1 |
| per2_o | output | 8 | Peripheral settings byte 2 |
| per3_o | output | 6 | Peripheral settings byte 3 |
| turbo_o | output | 1 | CPU clock select, 1 for double speed |

## Verification
The bench targets the phase locks. It writes the boot page while the overlay is still on, and it rewrites the machine type once the overlay is off and the type is non-zero. A design with an inverted or missing lock would move those outputs. It also writes the machine type twice while the type is still 00, which a design that locks after the first write would reject. It checks that a soft reset keeps a non-default setup, where a design that shares the hard reset path would fall back to the defaults. It also checks that a write in the same cycle as a hard reset is lost, and that a reset request lasts exactly one cycle with hard taking priority over soft.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t IX_ID    = 8'h00;
  localparam byte_t IX_VER   = 8'h01;
  localparam byte_t IX_RST   = 8'h02;
  localparam byte_t IX_MTYPE = 8'h03;
  localparam byte_t IX_PAGE  = 8'h04;
  localparam byte_t IX_PER1  = 8'h05;
  localparam byte_t IX_PER2  = 8'h06;
  localparam byte_t IX_TURBO = 8'h07;
  localparam byte_t IX_PER3  = 8'h08;

  localparam byte_t PER1_DEF = 8'h01;
  localparam byte_t PER2_DEF = 8'h00;
  localparam int    PER3_W   = 6;
  localparam logic [PER3_W-1:0] PER3_DEF = 6'h10;

  localparam logic [2:0] FLAG_POR  = 3'b100;
  localparam logic [2:0] FLAG_HARD = 3'b010;
  localparam logic [2:0] FLAG_SOFT = 3'b001;

  // machine type register is open during boot or while still in config mode
  function automatic logic mtype_open(input logic rom_on, input logic [1:0] mt);
    return rom_on || (mt == 2'b00);
  endfunction

  // boot page register is open only in config mode after the overlay is off
  function automatic logic page_open(input logic rom_on, input logic [1:0] mt);
    return !rom_on && (mt == 2'b00);
  endfunction

  function automatic byte_t widen_per3(input logic [PER3_W-1:0] v);
    return {{(BYTE_W-PER3_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/cfg_bus_dec.sv
module cfg_bus_dec #(
  parameter int AW = 16,
  parameter logic [AW-1:0] IDX_PORT = 16'h243B,
  parameter logic [AW-1:0] DAT_PORT = 16'h253B
) (
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  output logic          wr_idx,
  output logic          wr_dat,
  output logic          rd_dat
);
  logic hit_idx, hit_dat;
  assign hit_idx = (io_addr == IDX_PORT);
  assign hit_dat = (io_addr == DAT_PORT);
  assign wr_idx  = io_wr && hit_idx;
  assign wr_dat  = io_wr && hit_dat;
  assign rd_dat  = io_rd && hit_dat;
endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
  import cfgport_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  clr,
  input  logic  load,
  input  byte_t din,
  output byte_t idx
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    idx <= '0;
    else if (clr)  idx <= '0;
    else if (load) idx <= din;
  end
endmodule

// File: rtl/cfg_setup_regs.sv
module cfg_setup_regs
  import cfgport_pkg::*;
#(
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic              wr_dat,
  input  byte_t             idx,
  input  byte_t             wdata,
  output logic              rom_on,
  output logic [1:0]        mach_type,
  output logic [1:0]        timing,
  output logic [PAGE_W-1:0] boot_page,
  output byte_t             per1,
  output byte_t             per2,
  output logic [PER3_W-1:0] per3,
  output logic              turbo,
  output logic [2:0]        rst_flags,
  output logic              hard_req,
  output logic              soft_req,
  output logic              mt_acc,
  output logic              mt_blk,
  output logic              pg_acc,
  output logic              pg_blk
);
  logic wr_on, hit_rst, hit_mt, hit_pg;

  // a reset in the same cycle swallows the bus write
  assign wr_on   = wr_dat && !hard_rst && !soft_rst;
  assign hit_rst = wr_on && (idx == IX_RST);
  assign hit_mt  = wr_on && (idx == IX_MTYPE);
  assign hit_pg  = wr_on && (idx == IX_PAGE);

  assign mt_acc = hit_mt &&  mtype_open(rom_on, mach_type);
  assign mt_blk = hit_mt && !mtype_open(rom_on, mach_type);
  assign pg_acc = hit_pg &&  page_open(rom_on, mach_type);
  assign pg_blk = hit_pg && !page_open(rom_on, mach_type);

  // setup state: restored by power-on and hard reset, kept by soft reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rom_on <= 1'b1; mach_type <= '0; timing <= '0; boot_page <= '0;
      per1 <= PER1_DEF; per2 <= PER2_DEF; per3 <= PER3_DEF; turbo <= 1'b0;
    end else if (hard_rst) begin
      rom_on <= 1'b1; mach_type <= '0; timing <= '0; boot_page <= '0;
      per1 <= PER1_DEF; per2 <= PER2_DEF; per3 <= PER3_DEF; turbo <= 1'b0;
    end else begin
      if (mt_acc) begin
        timing    <= wdata[4:3];
        mach_type <= wdata[1:0];
        rom_on    <= 1'b0;
      end
      if (pg_acc) boot_page <= wdata[PAGE_W-1:0];
      if (wr_on && idx == IX_PER1)  per1  <= wdata;
      if (wr_on && idx == IX_PER2)  per2  <= wdata;
      if (wr_on && idx == IX_TURBO) turbo <= wdata[0];
      if (wr_on && idx == IX_PER3)  per3  <= wdata[PER3_W-1:0];
    end
  end

  // reset kind record and one-cycle reset requests
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_flags <= FLAG_POR;
      hard_req  <= 1'b0;
      soft_req  <= 1'b0;
    end else begin
      if (hard_rst)      rst_flags <= FLAG_HARD;
      else if (soft_rst) rst_flags <= FLAG_SOFT;
      hard_req <= hit_rst && wdata[1];
      soft_req <= hit_rst && wdata[0] && !wdata[1];
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfgport_pkg::*;
#(
  parameter byte_t MACH_ID  = 8'h0A,
  parameter byte_t CORE_VER = 8'h12
) (
  input  logic              rd_dat,
  input  byte_t             idx,
  input  logic [2:0]        rst_flags,
  input  byte_t             per1,
  input  byte_t             per2,
  input  logic [PER3_W-1:0] per3,
  input  logic              turbo,
  output byte_t             rdata
);
  byte_t sel;
  always_comb begin
    unique case (idx)
      IX_ID:    sel = MACH_ID;
      IX_VER:   sel = CORE_VER;
      IX_RST:   sel = {5'b0, rst_flags};
      IX_PER1:  sel = per1;
      IX_PER2:  sel = per2;
      IX_TURBO: sel = {7'b0, turbo};
      IX_PER3:  sel = widen_per3(per3);
      default:  sel = '0;   // write-only and unmapped indices
    endcase
  end
  assign rdata = rd_dat ? sel : '0;
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] IDX_PORT = 16'h243B,
  parameter logic [AW-1:0] DAT_PORT = 16'h253B,
  parameter int PAGE_W = 5,
  parameter logic [7:0] MACH_ID  = 8'h0A,
  parameter logic [7:0] CORE_VER = 8'h12
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic [AW-1:0]     io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              rom_overlay_o,
  output logic              hard_req_o,
  output logic              soft_req_o,
  output logic [1:0]        mach_type_o,
  output logic [1:0]        timing_o,
  output logic [PAGE_W-1:0] boot_page_o,
  output logic [7:0]        per1_o,
  output logic [7:0]        per2_o,
  output logic [5:0]        per3_o,
  output logic              turbo_o
);
  logic wr_idx, wr_dat, rd_dat;
  byte_t idx;
  logic [2:0] rst_flags;
  logic mt_acc, mt_blk, pg_acc, pg_blk;

  cfg_bus_dec #(.AW(AW), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .wr_idx(wr_idx), .wr_dat(wr_dat), .rd_dat(rd_dat)
  );

  cfg_index_reg u_idx (
    .clk(clk), .por_n(por_n), .clr(hard_rst || soft_rst),
    .load(wr_idx), .din(io_wdata), .idx(idx)
  );

  cfg_setup_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .por_n(por_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .wr_dat(wr_dat), .idx(idx), .wdata(io_wdata),
    .rom_on(rom_overlay_o), .mach_type(mach_type_o), .timing(timing_o),
    .boot_page(boot_page_o), .per1(per1_o), .per2(per2_o), .per3(per3_o),
    .turbo(turbo_o), .rst_flags(rst_flags),
    .hard_req(hard_req_o), .soft_req(soft_req_o),
    .mt_acc(mt_acc), .mt_blk(mt_blk), .pg_acc(pg_acc), .pg_blk(pg_blk)
  );

  cfg_read_mux #(.MACH_ID(MACH_ID), .CORE_VER(CORE_VER)) u_rd (
    .rd_dat(rd_dat), .idx(idx), .rst_flags(rst_flags),
    .per1(per1_o), .per2(per2_o), .per3(per3_o), .turbo(turbo_o),
    .rdata(io_rdata)
  );
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              por_n,
  input logic              hard_rst,
  input logic              soft_rst,
  input logic              mt_acc,
  input logic              mt_blk,
  input logic              pg_acc,
  input logic              pg_blk,
  input logic              rom_on,
  input logic [1:0]        mach_type,
  input logic [1:0]        timing,
  input logic [PAGE_W-1:0] boot_page,
  input logic [7:0]        per1,
  input logic [2:0]        rst_flags,
  input logic              hard_req,
  input logic              soft_req
);
  // R5
  mt_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    mt_blk |=> $stable(mach_type) && $stable(timing) && $stable(rom_on));
  // R5
  mt_rom_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    mt_acc |=> !rom_on);
  // R6
  pg_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    pg_blk |=> $stable(boot_page));
  // R6
  pg_phase_chk: assert property (@(posedge clk) disable iff (!por_n)
    pg_acc |-> !rom_on && mach_type == 2'b00);
  // R4
  req_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({hard_req, soft_req}));
  // R3
  flag_one_chk: assert property (@(posedge clk) disable iff (!por_n)
    $countones(rst_flags) == 1);
  // R9
  hard_def_chk: assert property (@(posedge clk) disable iff (!por_n)
    hard_rst |=> rom_on && mach_type == 2'b00 && boot_page == '0 && per1 == 8'h01);
  // R10
  soft_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (soft_rst && !hard_rst) |=> $stable(mach_type) && $stable(boot_page)
                                && $stable(per1) && rst_flags == 3'b001);
endmodule

bind cfgport_top cfgport_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .por_n(por_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
  .mt_acc(mt_acc), .mt_blk(mt_blk), .pg_acc(pg_acc), .pg_blk(pg_blk),
  .rom_on(rom_overlay_o), .mach_type(mach_type_o), .timing(timing_o),
  .boot_page(boot_page_o), .per1(per1_o), .rst_flags(rst_flags),
  .hard_req(hard_req_o), .soft_req(soft_req_o)
);

// File: tb/sim_cfgport_top.sv
`timescale 1ns/1ps
module sim_cfgport_top;
  localparam logic [15:0] IXP = 16'h243B;
  localparam logic [15:0] DTP = 16'h253B;
  localparam logic [1:0] OP_IX = 2'd0, OP_WD = 2'd1, OP_RD = 2'd2;
  localparam int NV = 28;
  // {op, value, expected}
  localparam logic [17:0] VEC [NV] = '{
    {OP_IX, 8'h00, 8'h00}, {OP_RD, 8'h00, 8'h0A},
    {OP_IX, 8'h01, 8'h00}, {OP_RD, 8'h00, 8'h12},
    {OP_WD, 8'hFF, 8'h00}, {OP_RD, 8'h00, 8'h12},
    {OP_IX, 8'h02, 8'h00}, {OP_RD, 8'h00, 8'h04},
    {OP_IX, 8'h05, 8'h00}, {OP_RD, 8'h00, 8'h01},
    {OP_WD, 8'h5A, 8'h00}, {OP_RD, 8'h00, 8'h5A},
    {OP_IX, 8'h06, 8'h00}, {OP_RD, 8'h00, 8'h00},
    {OP_WD, 8'hC3, 8'h00}, {OP_RD, 8'h00, 8'hC3},
    {OP_IX, 8'h07, 8'h00}, {OP_WD, 8'hFF, 8'h00},
    {OP_RD, 8'h00, 8'h01}, {OP_IX, 8'h08, 8'h00},
    {OP_RD, 8'h00, 8'h10}, {OP_WD, 8'hFF, 8'h00},
    {OP_RD, 8'h00, 8'h3F}, {OP_IX, 8'h03, 8'h00},
    {OP_RD, 8'h00, 8'h00}, {OP_IX, 8'h09, 8'h00},
    {OP_WD, 8'h77, 8'h00}, {OP_RD, 8'h00, 8'h00}
  };

  logic clk = 1'b0, por_n = 1'b0, hard_rst = 1'b0, soft_rst = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic rom_overlay_o, hard_req_o, soft_req_o, turbo_o;
  logic [1:0] mach_type_o, timing_o;
  logic [4:0] boot_page_o;
  logic [7:0] per1_o, per2_o;
  logic [5:0] per3_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfgport_top u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd_at(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic pulse_hard();
    @(negedge clk); hard_rst = 1'b1;
    @(negedge clk); hard_rst = 1'b0;
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // reset state (R9, R2)
    chk("R9 overlay", {7'b0, rom_overlay_o}, 8'h01);
    chk("R9 mtype", {6'b0, mach_type_o}, 8'h00);
    chk("R9 per1", per1_o, 8'h01);
    chk("R9 per3", {2'b0, per3_o}, 8'h10);
    chk("R2 idle rdata", io_rdata, 8'h00);
    rd_at(IXP, v); chk("R1 index port read", v, 8'h00);

    // table walk (R1 R2 R3 R7 R8 R9)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        OP_IX: wr_port(IXP, VEC[i][15:8]);
        OP_WD: wr_port(DTP, VEC[i][15:8]);
        default: begin
          rd_at(DTP, v);
          chk($sformatf("R1/R2/R3/R7/R8/R9 table step %0d", i), v, VEC[i][7:0]);
        end
      endcase
    end
    // R7 unmapped write touched nothing
    chk("R7 per1 kept", per1_o, 8'h5A);
    chk("R7 per2 kept", per2_o, 8'hC3);
    chk("R8 turbo", {7'b0, turbo_o}, 8'h01);

    // R6 page locked while overlay on
    wr_port(IXP, 8'h04); wr_port(DTP, 8'h07);
    chk("R6 page blocked in boot", {3'b0, boot_page_o}, 8'h00);
    // R5 accepted write, reserved bits ignored
    wr_port(IXP, 8'h03); wr_port(DTP, 8'hFB);
    chk("R5 timing", {6'b0, timing_o}, 8'h03);
    chk("R5 mtype", {6'b0, mach_type_o}, 8'h03);
    chk("R5 overlay off", {7'b0, rom_overlay_o}, 8'h00);
    wr_port(DTP, 8'h09);
    chk("R5 locked mtype", {6'b0, mach_type_o}, 8'h03);
    chk("R5 locked timing", {6'b0, timing_o}, 8'h03);
    wr_port(IXP, 8'h04); wr_port(DTP, 8'h11);
    chk("R6 page blocked after type set", {3'b0, boot_page_o}, 8'h00);

    // R10 soft reset keeps setup
    pulse_soft();
    chk("R10 mtype", {6'b0, mach_type_o}, 8'h03);
    chk("R10 overlay", {7'b0, rom_overlay_o}, 8'h00);
    chk("R10 per1", per1_o, 8'h5A);
    chk("R10 turbo", {7'b0, turbo_o}, 8'h01);
    rd_at(DTP, v); chk("R1 index cleared by soft", v, 8'h0A);
    wr_port(IXP, 8'h02); rd_at(DTP, v); chk("R3 soft flag", v, 8'h01);

    // R9 hard reset restores defaults
    pulse_hard();
    chk("R9 hard overlay", {7'b0, rom_overlay_o}, 8'h01);
    chk("R9 hard mtype", {6'b0, mach_type_o}, 8'h00);
    chk("R9 hard timing", {6'b0, timing_o}, 8'h00);
    chk("R9 hard per1", per1_o, 8'h01);
    chk("R9 hard per2", per2_o, 8'h00);
    chk("R9 hard per3", {2'b0, per3_o}, 8'h10);
    chk("R9 hard turbo", {7'b0, turbo_o}, 8'h00);
    wr_port(IXP, 8'h02); rd_at(DTP, v); chk("R3 hard flag", v, 8'h02);

    // config mode sequence (R5, R6)
    wr_port(IXP, 8'h03); wr_port(DTP, 8'h10);
    chk("R5 timing cfg", {6'b0, timing_o}, 8'h02);
    chk("R5 overlay cfg", {7'b0, rom_overlay_o}, 8'h00);
    wr_port(IXP, 8'h04); wr_port(DTP, 8'h1F);
    chk("R6 page open", {3'b0, boot_page_o}, 8'h1F);
    wr_port(DTP, 8'hE5);
    chk("R6 page field", {3'b0, boot_page_o}, 8'h05);
    wr_port(IXP, 8'h03); wr_port(DTP, 8'h01);
    chk("R5 second write in config", {6'b0, mach_type_o}, 8'h01);
    wr_port(IXP, 8'h04); wr_port(DTP, 8'h0A);
    chk("R6 page locked again", {3'b0, boot_page_o}, 8'h05);

    // R4 reset requests
    wr_port(IXP, 8'h02); wr_port(DTP, 8'h03);
    chk("R4 hard req high", {6'b0, hard_req_o, soft_req_o}, 8'h02);
    @(negedge clk);
    chk("R4 hard req one cycle", {6'b0, hard_req_o, soft_req_o}, 8'h00);
    wr_port(DTP, 8'h01);
    chk("R4 soft req high", {6'b0, hard_req_o, soft_req_o}, 8'h01);
    @(negedge clk);
    chk("R4 soft req one cycle", {6'b0, hard_req_o, soft_req_o}, 8'h00);
    rd_at(DTP, v); chk("R3 flags unchanged by write", v, 8'h02);

    // R11 reset beats a same-cycle write
    wr_port(IXP, 8'h05);
    @(negedge clk); io_addr = DTP; io_wdata = 8'h77; io_wr = 1'b1; hard_rst = 1'b1;
    @(negedge clk); io_wr = 1'b0; hard_rst = 1'b0;
    chk("R11 write lost to hard reset", per1_o, 8'h01);
    @(negedge clk); por_n = 1'b0; soft_rst = 1'b1;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    wr_port(IXP, 8'h02); rd_at(DTP, v); chk("R11 soft after por", v, 8'h01);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    wr_port(IXP, 8'h02); rd_at(DTP, v); chk("R3 por flag", v, 8'h04);

    finish_run();
  end
endmodule